// File: doc/BRIEF.md
# Double-Buffered Backlight PWM Generator

This block produces one pulse-width-modulated waveform for a display backlight. Software programs it through a small word-wide register port with address, write data, write strobe and read data. Three quantities set the waveform: a prescale divider, a period count and a high-time count. Writes place these values in staging registers. A separate active copy drives the prescaler and the period counter, so a half-written configuration never reaches the output.

A commit is a write of 1 followed by a write of 0 to the commit bit. The commit captures the staged values. If the channel is running, the captured values are loaded into the active copy at the next period boundary, so the period in progress completes with its old settings. If the channel is off, the values are loaded at once. A direct mode bit bypasses the staging, and configuration writes then take effect on the next clock. While the enable bit is 0, the counters are held at zero and the output is low. Enabling the channel therefore always starts a fresh period.

Top module: `bl_pwm`

## Requirements
- R1: After reset, every register reads 0, the active configuration is all zeros and `pwm_out` is low.
- R2: The register map is as follows. Enable is bit 0 at 0x00. Commit is bit 0 at 0x08. Direct mode is bit 0 at 0x0C. The divider is bits [25:16] at 0x10. The period is bits [11:0] and the high time is bits [28:16] at 0x14. Each register reads back its last written fields, and undefined bits read 0. A write changes no other register, and a write to an unmapped address changes nothing.
- R3: With active divider D, period P and high time H, where 1 ≤ H ≤ P, the output repeats every (D+1)·(P+1) clocks and is high for the first (D+1)·H clocks of each period.
- R4: A high time of at least P+1 holds the output high continuously. A high time of 0 holds it low.
- R5: While enable is 0, the output is low and the counters rest at zero. The clock edge that sets enable starts a new period, so the output is high from the next cycle and the first pulse has its full length.
- R6: With direct mode off, configuration writes do not change the output until a commit. A commit is a write of 1 and then a write of 0 to the commit bit. Writing 1 alone commits nothing.
- R7: With the channel running and direct mode off, a committed configuration takes effect at the next period boundary. The period in progress finishes with its old divider, period and high time.
- R8: A commit issued while the channel is disabled loads the active configuration immediately, so the first period after enabling uses the new values.
- R9: With direct mode on, configuration writes reach the active configuration at the same clock edge, without a commit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_we | input | 1 | Write strobe, one word per cycle |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| pwm_out | output | 1 | PWM waveform |

## Verification
A wrong active configuration, such as a commit applied too early or a stale staged value, appears at the port as a wrong high-time or period length. This shows within the first full period after the commit. A counter that fails to restart, or is off by one, changes the length of the very first pulse after enable, so the bench measures that pulse separately from the steady-state periods. Commits issued mid-pulse show whether the period in progress kept its old shape. Switching to direct mode shows whether writes bypass the staging.

// File: rtl/bl_pwm_pkg.sv
package bl_pwm_pkg;

    localparam int DW      = 32;
    localparam int AW      = 8;
    localparam int DIV_W   = 10;
    localparam int PER_W   = 12;
    localparam int HI_W    = 13;
    localparam int DIV_LSB = 16;
    localparam int PER_LSB = 0;
    localparam int HI_LSB  = 16;

    localparam logic [AW-1:0] OFF_EN   = AW'(8'h00);
    localparam logic [AW-1:0] OFF_CMT  = AW'(8'h08);
    localparam logic [AW-1:0] OFF_MODE = AW'(8'h0C);
    localparam logic [AW-1:0] OFF_CFG0 = AW'(8'h10);
    localparam logic [AW-1:0] OFF_CFG1 = AW'(8'h14);

    typedef struct packed {
        logic [DIV_W-1:0] div;
        logic [PER_W-1:0] per;
        logic [HI_W-1:0]  hi;
    } pwm_cfg_t;

endpackage

// File: rtl/bl_pwm_regs.sv
module bl_pwm_regs
    import bl_pwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    input  logic          period_end,
    output logic [DW-1:0] reg_rdata,
    output logic          chan_en,
    output logic          direct,
    output pwm_cfg_t      act_cfg
);

    typedef struct packed {
        logic     en;
        logic     byp;
        logic     cmt;
        logic     pend;
        pwm_cfg_t shd;
        pwm_cfg_t stg;
        pwm_cfg_t act;
    } regs_t;

    regs_t st_d, st_q;
    logic  cmt_req;
    logic  unused_wbits;

    assign unused_wbits = ^{reg_wdata[DW-1:HI_LSB+HI_W], reg_wdata[DIV_LSB-1:PER_LSB+PER_W]};

    always_comb begin
        st_d    = st_q;
        cmt_req = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                OFF_EN:   st_d.en  = reg_wdata[0];
                OFF_MODE: st_d.byp = reg_wdata[0];
                OFF_CMT: begin
                    st_d.cmt = reg_wdata[0];
                    cmt_req  = st_q.cmt & ~reg_wdata[0];
                end
                OFF_CFG0: st_d.shd.div = reg_wdata[DIV_LSB +: DIV_W];
                OFF_CFG1: begin
                    st_d.shd.per = reg_wdata[PER_LSB +: PER_W];
                    st_d.shd.hi  = reg_wdata[HI_LSB +: HI_W];
                end
                default: ;
            endcase
        end
        if (cmt_req) begin
            st_d.stg = st_q.shd;
        end
        if (st_d.byp) begin
            st_d.act  = st_d.shd;
            st_d.pend = 1'b0;
        end else if (cmt_req || st_q.pend) begin
            if (!st_q.en || period_end) begin
                st_d.act  = cmt_req ? st_q.shd : st_q.stg;
                st_d.pend = 1'b0;
            end else begin
                st_d.pend = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            OFF_EN:   reg_rdata[0] = st_q.en;
            OFF_CMT:  reg_rdata[0] = st_q.cmt;
            OFF_MODE: reg_rdata[0] = st_q.byp;
            OFF_CFG0: reg_rdata[DIV_LSB +: DIV_W] = st_q.shd.div;
            OFF_CFG1: begin
                reg_rdata[PER_LSB +: PER_W] = st_q.shd.per;
                reg_rdata[HI_LSB +: HI_W]   = st_q.shd.hi;
            end
            default: ;
        endcase
    end

    assign chan_en = st_q.en;
    assign direct  = st_q.byp;
    assign act_cfg = st_q.act;

    AST_PEND_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pend && period_end) |=> !st_q.pend); // R7
    AST_DIRECT_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.byp |-> (st_q.act == st_q.shd)); // R9

endmodule

// File: rtl/bl_pwm_core.sv
module bl_pwm_core
    import bl_pwm_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  pwm_cfg_t cfg,
    output logic     period_end,
    output logic     pwm_out
);

    typedef struct packed {
        logic [DIV_W-1:0] pre;
        logic [PER_W-1:0] per;
    } cnt_t;

    cnt_t c_d, c_q;
    logic tick;
    logic per_last;

    always_comb begin
        tick       = (c_q.pre >= cfg.div);
        per_last   = (c_q.per >= cfg.per);
        period_end = en && tick && per_last;
        c_d        = c_q;
        if (!en) begin
            c_d = '0;
        end else if (tick) begin
            c_d.pre = '0;
            c_d.per = per_last ? '0 : c_q.per + 1'b1;
        end else begin
            c_d.pre = c_q.pre + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '0;
        end else begin
            c_q <= c_d;
        end
    end

    assign pwm_out = en && ({1'b0, c_q.per} < cfg.hi);

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        period_end |=> (c_q.pre == '0 && c_q.per == '0)); // R3
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (c_q.pre == '0 && c_q.per == '0)); // R5

endmodule

// File: rtl/bl_pwm.sv
module bl_pwm
    import bl_pwm_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] reg_addr,
    input  logic [DW-1:0] reg_wdata,
    input  logic          reg_we,
    output logic [DW-1:0] reg_rdata,
    output logic          pwm_out
);

    logic     chan_en;
    logic     direct;
    logic     period_end;
    pwm_cfg_t act_cfg;

    bl_pwm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_we     (reg_we),
        .period_end (period_end),
        .reg_rdata  (reg_rdata),
        .chan_en    (chan_en),
        .direct     (direct),
        .act_cfg    (act_cfg)
    );

    bl_pwm_core u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (chan_en),
        .cfg        (act_cfg),
        .period_end (period_end),
        .pwm_out    (pwm_out)
    );

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !chan_en |-> !pwm_out); // R5
    AST_LOAD_AT_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
        (!direct && $past(!direct) && $past(chan_en) && (act_cfg != $past(act_cfg)))
        |-> $past(period_end)); // R7

endmodule

// File: tb/bl_pwm_tb.sv
module bl_pwm_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic        reg_we = 1'b0;
    logic [31:0] reg_rdata;
    logic        pwm_out;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    int cyc = 0, rise_last = 0, fall_last = 0, n_rise = 0, n_fall = 0;
    logic prev_out = 1'b0;

    logic [31:0] m_en = 0, m_cmt = 0, m_mode = 0, m_c0 = 0, m_c1 = 0;

    always #10 clk = ~clk;

    bl_pwm u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_we    (reg_we),
        .reg_rdata (reg_rdata),
        .pwm_out   (pwm_out)
    );

    always @(negedge clk) begin
        cyc = cyc + 1;
        if (pwm_out && !prev_out) begin rise_last = cyc; n_rise = n_rise + 1; end
        if (!pwm_out && prev_out) begin fall_last = cyc; n_fall = n_fall + 1; end
        prev_out = pwm_out;
    end

    function automatic int exp_hi(int d, int h); return (d + 1) * h; endfunction
    function automatic int exp_per(int d, int p); return (d + 1) * (p + 1); endfunction
    function automatic logic [31:0] mk0(int d); return 32'(d) << 16; endfunction
    function automatic logic [31:0] mk1(int p, int h); return (32'(h) << 16) | 32'(p); endfunction

    function automatic logic [31:0] exp_rd(logic [7:0] a);
        case (a)
            8'h00: return m_en & 32'h1;
            8'h08: return m_cmt & 32'h1;
            8'h0C: return m_mode & 32'h1;
            8'h10: return m_c0 & 32'h03FF_0000;
            8'h14: return m_c1 & 32'h1FFF_0FFF;
            default: return 32'h0;
        endcase
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        tests = tests + 1;
        if (act != exp) begin
            fails = fails + 1;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        case (a)
            8'h00: m_en = d;
            8'h08: m_cmt = d;
            8'h0C: m_mode = d;
            8'h10: m_c0 = d;
            8'h14: m_c1 = d;
            default: ;
        endcase
        @(negedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic commit;
        wr(8'h08, 32'h1);
        wr(8'h08, 32'h0);
    endtask

    task automatic rd_chk(input string tag, input logic [7:0] a);
        reg_addr = a; #1;
        chk(tag, int'(reg_rdata), int'(exp_rd(a)));
    endtask

    task automatic wait_rise;
        int k = n_rise;
        for (int i = 0; i < 5000 && n_rise == k; i++) begin @(negedge clk); #1; end
        if (n_rise == k) chk("R3 rise timeout", 0, 1);
    endtask

    task automatic wait_fall;
        int k = n_fall;
        for (int i = 0; i < 5000 && n_fall == k; i++) begin @(negedge clk); #1; end
        if (n_fall == k) chk("R3 fall timeout", 0, 1);
    endtask

    task automatic measure(output int hi, output int per);
        int r1;
        wait_rise; r1 = rise_last;
        wait_fall; hi = fall_last - r1;
        wait_rise; per = rise_last - r1;
    endtask

    task automatic window_ones(input int n, output int ones);
        ones = 0;
        for (int i = 0; i < n; i++) begin @(negedge clk); #1; ones += int'(pwm_out); end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            chk("R3 watchdog", 1, 0);
            summary;
            $finish;
        end
    end

    initial begin
        int s, d, p, h, hi, per, ones, r2;
        logic [7:0] addrs [5];
        addrs = '{8'h00, 8'h08, 8'h0C, 8'h10, 8'h14};
        s = $urandom(32'h5EED_0042);

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk); #1;
        chk("R1 out after reset", int'(pwm_out), 0);
        foreach (addrs[i]) rd_chk("R1 reg after reset", addrs[i]);

        // R2: random writes, then all registers compared
        for (int i = 0; i < 24; i++) begin
            logic [7:0] a;
            a = (i % 6 == 5) ? 8'h04 : addrs[$urandom % 5];
            wr(a, $urandom);
            foreach (addrs[j]) rd_chk("R2 readback", addrs[j]);
        end
        wr(8'h00, 0); wr(8'h0C, 0); wr(8'h08, 0);
        rd_chk("R2 mode cleared", 8'h0C);

        // R3, R5, R8: random configurations, committed while disabled
        for (int i = 0; i < 10; i++) begin
            d = $urandom % 4; p = 1 + $urandom % 15; h = 1 + $urandom % p;
            wr(8'h00, 0);
            window_ones(8, ones);
            chk("R5 low while disabled", ones, 0);
            wr(8'h10, mk0(d)); wr(8'h14, mk1(p, h));
            commit;
            wr(8'h00, 1);
            chk("R5 high right after enable", int'(pwm_out), 1);
            wait_fall;
            chk("R8 first pulse uses new config", fall_last - rise_last, exp_hi(d, h));
            measure(hi, per);
            chk("R3 high time", hi, exp_hi(d, h));
            chk("R3 period", per, exp_per(d, p));
        end

        // R6: staged writes without commit
        wr(8'h00, 0); wr(8'h10, mk0(1)); wr(8'h14, mk1(7, 3)); commit; wr(8'h00, 1);
        wr(8'h10, mk0(0)); wr(8'h14, mk1(3, 1));
        measure(hi, per);
        chk("R6 no commit high", hi, 6);
        chk("R6 no commit period", per, 16);
        wr(8'h08, 1);
        measure(hi, per);
        chk("R6 write 1 alone high", hi, 6);
        chk("R6 write 1 alone period", per, 16);
        wr(8'h08, 0);
        measure(hi, per);
        chk("R6 committed high", hi, 1);
        chk("R6 committed period", per, 4);

        // R7: commit in the middle of a pulse
        wr(8'h00, 0); wr(8'h10, mk0(0)); wr(8'h14, mk1(19, 10)); commit; wr(8'h00, 1);
        wait_rise;
        wr(8'h14, mk1(9, 2));
        commit;
        wait_fall;
        chk("R7 old high kept", fall_last - rise_last, 10);
        r2 = rise_last;
        wait_rise;
        chk("R7 old period kept", rise_last - r2, 20);
        r2 = rise_last;
        wait_fall;
        chk("R7 new high after boundary", fall_last - r2, 2);
        wait_rise;
        chk("R7 new period after boundary", rise_last - r2, 10);

        // R9: direct mode
        wr(8'h0C, 1);
        wr(8'h14, mk1(9, 7));
        measure(hi, per);
        chk("R9 direct high", hi, 7);
        chk("R9 direct period", per, 10);
        wr(8'h0C, 0);

        // R4: saturated and zero high time
        wr(8'h00, 0); wr(8'h14, mk1(4, 5)); commit; wr(8'h00, 1);
        window_ones(40, ones);
        chk("R4 high equals period+1", ones, 40);
        wr(8'h14, mk1(4, 13'h1FFF)); commit;
        window_ones(40, ones);
        chk("R4 high at maximum", ones, 40);
        wr(8'h14, mk1(4, 0)); commit;
        repeat (10) @(negedge clk);
        #1;
        window_ones(40, ones);
        chk("R4 zero high", ones, 0);

        done = 1'b1;
        summary;
        $finish;
    end

endmodule